// File: doc/BRIEF.md
# Flash Protected Range Checker

This block guards a serial flash against unwanted cycles. It holds five protected-range registers and one minimum-address register. It judges every flash cycle, identified by its 25-bit linear address and its kind (read, or write/erase), against those registers. Each range covers whole 4 KiB pages. A range carries its own write-protect flag, which also covers erases, and its own read-protect flag.

Firmware programs the ranges through a simple register write port and then raises the lockdown input. From that point until reset the ranges are enforced and the configuration is frozen. The minimum-address floor applies at all times. Every request gets a registered grant or deny one clock later. A deny also sets a sticky violation flag, which is cleared by a write-one pulse.

Top module: `flash_prot_check`

## Requirements
- R1: `cfg_sel_i` values 0 to 4 select a range register and value 5 selects the floor register. In a range word, bit 31 is the write-protect flag, bit 15 is the read-protect flag, bits 28:16 hold the upper page and bits 12:0 hold the lower page. A page is address bits 24:12.
- R2: A range contains an address when the address page is at least the lower page and at most the upper page. This means the upper bound reaches the last byte of its page (offset 0xFFF) and the lower bound starts at offset 0x000. A range whose upper page is below its lower page contains no address.
- R3: Once locked, a write/erase request (`req_write_i`=1) is denied if any range with its write-protect flag set contains the address. The write-protect flag has no effect on reads.
- R4: Once locked, a read request (`req_write_i`=0) is denied if any range with its read-protect flag set contains the address. The read-protect flag has no effect on writes.
- R5: Before lockdown, the range contents affect no decision.
- R6: A high `lock_i` at a clock edge locks the block until reset. While locked, writes to any register, including the floor, are ignored. A write in the same cycle as the first `lock_i` is still accepted.
- R7: The floor register stores the written data masked to bits 23:8. A request of either kind whose address is below the floor is denied, whether or not the block is locked.
- R8: A request sampled at a clock edge produces `resp_valid_o` after that edge for one cycle, with exactly one of `resp_grant_o` and `resp_deny_o` high. With no request, `resp_valid_o` stays low. The decision uses the configuration as it stood before that edge.
- R9: A deny sets `viol_o` in the same cycle that `resp_deny_o` is shown. `viol_o` holds until a `viol_clr_i` pulse. If a new deny and a clear arrive at the same edge, the set wins.
- R10: After reset the block is unlocked, all ranges are zero, the floor is zero, no response is given and `viol_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select: 0-4 are the ranges, 5 is the floor |
| cfg_wdata_i | input | 32 | Register write data |
| lock_i | input | 1 | Lockdown request, sticky once sampled |
| req_valid_i | input | 1 | Flash cycle request valid |
| req_addr_i | input | 25 | Linear flash address of the request |
| req_write_i | input | 1 | 1 for write/erase, 0 for read |
| viol_clr_i | input | 1 | Write-one clear of the violation flag |
| resp_valid_o | output | 1 | Decision valid, one cycle after the request |
| resp_grant_o | output | 1 | The cycle is allowed |
| resp_deny_o | output | 1 | The cycle is blocked |
| viol_o | output | 1 | Sticky violation flag |

## Verification
Two pairs of events can land on the same edge: a violation being set and being cleared, and a register write coinciding with the first lockdown sample. The bench drives a denied request together with a `viol_clr_i` pulse and requires `viol_o` to read high afterwards. A lone clear must then bring it low. The bench also writes a range after lockdown and confirms, through later grant/deny decisions, that the old setting still governs.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned CFG_W      = 32;
  localparam int unsigned PG_W       = 13;
  localparam int unsigned WP_BIT     = 31;
  localparam int unsigned RP_BIT     = 15;
  localparam int unsigned HI_LSB     = 16;
  localparam int unsigned LO_LSB     = 0;
  localparam logic [CFG_W-1:0] FLOOR_MASK = 32'h00FF_FF00;

  typedef struct packed {
    logic            wp;
    logic            rp;
    logic [PG_W-1:0] hi;
    logic [PG_W-1:0] lo;
  } range_cfg_t;

  function automatic range_cfg_t unpack_range(input logic [CFG_W-1:0] w);
    range_cfg_t r;
    r.wp = w[WP_BIT];
    r.rp = w[RP_BIT];
    r.hi = w[HI_LSB +: PG_W];
    r.lo = w[LO_LSB +: PG_W];
    return r;
  endfunction
endpackage

// File: rtl/prc_range_cell.sv
module prc_range_cell
  import prc_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic [PG_W-1:0]  page_i,
  output logic             wp_hit_o,
  output logic             rp_hit_o
);
  range_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= unpack_range(wdata_i);
  end

  logic inside_w;
  assign inside_w = (page_i >= cfg_q.lo) && (page_i <= cfg_q.hi);
  assign wp_hit_o = inside_w && cfg_q.wp;
  assign rp_hit_o = inside_w && cfg_q.rp;

  AST_INVERTED_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.hi < cfg_q.lo) |-> !(wp_hit_o || rp_hit_o)); // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_q)); // R6
endmodule

// File: rtl/prc_floor.sv
module prc_floor
  import prc_pkg::*;
#(
  parameter int unsigned ADDR_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              below_o
);
  logic [ADDR_W-1:0] floor_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      floor_q <= '0;
    else if (wr_en_i) floor_q <= ADDR_W'(wdata_i & FLOOR_MASK);
  end

  assign below_o = addr_i < floor_q;

  AST_FLOOR_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == '0) && below_o |-> (floor_q != '0)); // R7
endmodule

// File: rtl/prc_resp.sv
module prc_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic deny_i,
  input  logic viol_clr_i,
  output logic resp_valid_o,
  output logic resp_grant_o,
  output logic resp_deny_o,
  output logic viol_o
);
  logic vld_q, deny_q, viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      deny_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      vld_q  <= req_valid_i;
      deny_q <= req_valid_i && deny_i;
      // set takes priority over clear
      if (req_valid_i && deny_i) viol_q <= 1'b1;
      else if (viol_clr_i)       viol_q <= 1'b0;
    end
  end

  assign resp_valid_o = vld_q;
  assign resp_deny_o  = deny_q;
  assign resp_grant_o = vld_q && !deny_q;
  assign viol_o       = viol_q;

  AST_RESP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o); // R8
  AST_RESP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o && !resp_deny_o); // R8
  AST_RESP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $onehot({resp_grant_o, resp_deny_o})); // R8
  AST_VIOL_ON_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_deny_o |-> viol_o); // R9
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o && !viol_clr_i |=> viol_o); // R9
endmodule

// File: rtl/flash_prot_check.sv
module flash_prot_check
  import prc_pkg::*;
#(
  parameter int unsigned N_RANGES   = 5,
  parameter int unsigned ADDR_W     = 25,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              lock_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              viol_clr_i,
  output logic              resp_valid_o,
  output logic              resp_grant_o,
  output logic              resp_deny_o,
  output logic              viol_o
);
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned FLOOR_SEL = N_RANGES;

  logic lock_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lock_q <= 1'b0;
    else if (lock_i) lock_q <= 1'b1;
  end

  logic cfg_ok;
  assign cfg_ok = cfg_we_i && !lock_q;

  logic [PG_W-1:0] page_w;
  assign page_w = PG_W'(req_addr_i >> PAGE_SHIFT);

  logic [N_RANGES-1:0] wp_hit, rp_hit;

  for (genvar g = 0; g < N_RANGES; g++) begin : g_range
    prc_range_cell #(.IDX(g)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (cfg_ok && (cfg_sel_i == SEL_W'(g))),
      .wdata_i  (cfg_wdata_i),
      .page_i   (page_w),
      .wp_hit_o (wp_hit[g]),
      .rp_hit_o (rp_hit[g])
    );
  end

  logic below_floor;
  prc_floor #(.ADDR_W(ADDR_W)) u_floor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_ok && (cfg_sel_i == SEL_W'(FLOOR_SEL))),
    .wdata_i (cfg_wdata_i),
    .addr_i  (req_addr_i),
    .below_o (below_floor)
  );

  logic range_deny, deny_c;
  assign range_deny = lock_q && (req_write_i ? |wp_hit : |rp_hit);
  assign deny_c     = below_floor || range_deny;

  prc_resp u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .deny_i       (deny_c),
    .viol_clr_i   (viol_clr_i),
    .resp_valid_o (resp_valid_o),
    .resp_grant_o (resp_grant_o),
    .resp_deny_o  (resp_deny_o),
    .viol_o       (viol_o)
  );

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R6
  AST_UNLOCKED_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !lock_q && !below_floor |=> resp_grant_o); // R5
  AST_FLOOR_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && below_floor |=> resp_deny_o); // R7
endmodule

// File: tb/flash_prot_check_tb.sv
module flash_prot_check_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        lock_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [24:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        viol_clr_i = 1'b0;
  logic        resp_valid_o, resp_grant_o, resp_deny_o, viol_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  flash_prot_check u_dut (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .lock_i,
    .req_valid_i, .req_addr_i, .req_write_i, .viol_clr_i,
    .resp_valid_o, .resp_grant_o, .resp_deny_o, .viol_o
  );

  function automatic logic [31:0] rng(input logic wp, input logic rp,
                                      input logic [12:0] hi, input logic [12:0] lo);
    return {wp, 2'b00, hi, rp, 2'b00, lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_lock();
    @(negedge clk_i);
    lock_i = 1'b1;
    @(negedge clk_i);
    lock_i = 1'b0;
  endtask

  // request then sample response at next negedge
  task automatic req(input string tag, input logic [24:0] a, input logic wr, input logic exp_deny);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk({tag, " valid"}, 32'(resp_valid_o), 32'd1);
    chk({tag, " deny"},  32'(resp_deny_o),  32'(exp_deny));
    chk({tag, " grant"}, 32'(resp_grant_o), 32'(!exp_deny));
  endtask

  task automatic clear_viol();
    @(negedge clk_i);
    viol_clr_i = 1'b1;
    @(negedge clk_i);
    viol_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 resp_valid", 32'(resp_valid_o), 32'd0);
    chk("R10 viol", 32'(viol_o), 32'd0);
    req("R10 floor zero read", 25'h0, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R8 idle no response", 32'(resp_valid_o), 32'd0);
  endtask

  task automatic t_prelock();
    cfg_wr(3'd0, rng(1'b1, 1'b0, 13'h01F, 13'h010));
    cfg_wr(3'd1, rng(1'b0, 1'b1, 13'h100, 13'h100));
    cfg_wr(3'd2, rng(1'b1, 1'b1, 13'h005, 13'h006));
    cfg_wr(3'd4, rng(1'b1, 1'b1, 13'h1FFF, 13'h1FFF));
    req("R5 write in range before lock", 25'h0010000, 1'b1, 1'b0);
    req("R5 read in range before lock", 25'h0100ABC, 1'b0, 1'b0);
    chk("R5 viol untouched", 32'(viol_o), 32'd0);
  endtask

  task automatic t_floor();
    cfg_wr(3'd5, 32'hFF00_1234);
    req("R7 below floor", 25'h00011FF, 1'b0, 1'b1);
    chk("R9 viol set", 32'(viol_o), 32'd1);
    req("R7 at floor", 25'h0001200, 1'b1, 1'b0);
    clear_viol();
    chk("R9 viol cleared", 32'(viol_o), 32'd0);
    cfg_wr(3'd5, 32'h0);
    req("R7 floor removed", 25'h00011FF, 1'b0, 1'b0);
  endtask

  task automatic t_locked();
    do_lock();
    req("R3 write low edge", 25'h0010000, 1'b1, 1'b1);
    req("R2 upper page extended", 25'h001FFFF, 1'b1, 1'b1);
    req("R2 above upper", 25'h0020000, 1'b1, 1'b0);
    req("R2 below lower", 25'h000FFFF, 1'b1, 1'b0);
    req("R3 read ignores wp", 25'h0015000, 1'b0, 1'b0);
    req("R4 read in rp range", 25'h0100ABC, 1'b0, 1'b1);
    req("R4 write ignores rp", 25'h0100ABC, 1'b1, 1'b0);
    req("R2 inverted range lo", 25'h0005000, 1'b1, 1'b0);
    req("R2 inverted range hi", 25'h0006000, 1'b0, 1'b0);
    req("R1 range 4 top page", 25'h1FFFFFF, 1'b1, 1'b1);
    req("R1 range 4 top page read", 25'h1FFF000, 1'b0, 1'b1);
  endtask

  task automatic t_frozen();
    cfg_wr(3'd0, 32'h0);
    cfg_wr(3'd5, 32'h00FF_FF00);
    req("R6 range write ignored", 25'h0018000, 1'b1, 1'b1);
    req("R6 floor write ignored", 25'h0000100, 1'b0, 1'b0);
    repeat (3) @(negedge clk_i);
    req("R6 lock still held", 25'h0010000, 1'b1, 1'b1);
  endtask

  task automatic t_viol_race();
    clear_viol();
    chk("R9 clear alone", 32'(viol_o), 32'd0);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 25'h0010000; req_write_i = 1'b1; viol_clr_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0; viol_clr_i = 1'b0;
    chk("R9 set wins over clear", 32'(viol_o), 32'd1);
    chk("R9 deny shown", 32'(resp_deny_o), 32'd1);
    clear_viol();
    chk("R9 later clear", 32'(viol_o), 32'd0);
  endtask

  task automatic t_lock_same_cycle();
    do_reset();
    req("R10 unlocked after reset", 25'h0010000, 1'b1, 1'b0);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = 3'd3; cfg_wdata_i = rng(1'b1, 1'b0, 13'h040, 13'h040);
    lock_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0; lock_i = 1'b0;
    req("R6 write with first lock kept", 25'h0040123, 1'b1, 1'b1);
    req("R10 ranges cleared by reset", 25'h0010000, 1'b1, 1'b0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_prelock();
    t_floor();
    t_locked();
    t_frozen();
    t_viol_race();
    t_lock_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule